// File: doc/BRIEF.md
# Radix-2 FFT Stage Sequencer

This block drives the control side of one stage in a pipelined radix-2 FFT. The full transform is 1024 points over ten stages, and one instance of the block serves each stage. Each stage has its own dual-port working buffer, its own twiddle table and a butterfly datapath with a fixed latency. The sequencer owns none of these. It only produces the strobes and addresses that move a frame through them.

When the stage upstream finishes writing a frame, it sends a one-cycle `frame_ready` pulse. The sequencer records the pulse as a pending request. It clears that request as it starts the frame, and then issues one butterfly per cycle, 2^(LOG2-1) in total. For each butterfly it drives the two operand read addresses and the twiddle index. The same addresses come back out as write-back addresses once the butterfly latency has passed. After the last write-back, the sequencer pulses `stage_done`, which serves as the `frame_ready` of the next stage.

Two state machines share the work. The issue machine runs idle, issue and drain phases around a butterfly counter. The retire machine counts delayed write strobes and raises the completion pulse. The parameter `STAGE` sets the pairing distance and the width of the twiddle index.

Top module: `fft_stage_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, both machines return to idle, the butterfly counter and the pending request clear, and `rd_en`, `wr_en` and `stage_done` are 0 after that edge.
- R2: A `frame_ready` pulse sampled at edge P makes `rd_en` high for exactly NB = 2^(LOG2-1) consecutive cycles, starting after edge P+1. Butterfly index k runs from 0 to NB-1, one per cycle.
- R3: For butterfly k at stage s, `rd_addr_a` = ((k >> s) << (s+1)) | (k mod 2^s) and `rd_addr_b` = `rd_addr_a` + 2^s. Bit s of `rd_addr_a` is therefore always 0.
- R4: `tw_idx` equals k mod 2^s and is max(s,1) bits wide. At stage 0 it is constantly 0.
- R5: `wr_en`, `wr_addr_a` and `wr_addr_b` repeat `rd_en`, `rd_addr_a` and `rd_addr_b` exactly LAT cycles later (LAT = 3 by default).
- R6: `stage_done` is high for exactly one cycle, the cycle right after the cycle that carries the final write-back of the frame.
- R7: A `frame_ready` pulse that arrives while a frame is in progress is kept. Exactly one further frame starts, two cycles after `stage_done`, and no third frame follows without a new pulse.
- R8: A reset in the middle of a frame abandons that frame and discards any pending request. No further enables or `stage_done` appear until a new `frame_ready` pulse arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_ready | input | 1 | One-cycle pulse: the upstream buffer holds a complete frame |
| rd_en | output | 1 | Operand read strobe for both buffer ports |
| rd_addr_a | output | LOG2 | Upper operand address |
| rd_addr_b | output | LOG2 | Lower operand address |
| tw_idx | output | max(STAGE,1) | Twiddle table index |
| wr_en | output | 1 | Result write strobe |
| wr_addr_a | output | LOG2 | Upper result address |
| wr_addr_b | output | LOG2 | Lower result address |
| stage_done | output | 1 | One-cycle frame completion pulse |

## Verification
Three instances run side by side: stage 0, a middle stage and the last stage, on a 32-point configuration. The bench checks every address and index on every cycle of every frame. This catches an address generator that mishandles the two end stages, where the pairing bit sits at the bottom or the top. It also catches a stage-0 twiddle that is not constant.

The write-back path is checked cycle by cycle, so a delay one short or one long shows up as shifted write strobes. A completion pulse that is early, late or two cycles wide is reported in the same way. A second request sent mid-frame must give exactly one follow-on frame at a fixed gap. A design that dropped the request would show no second frame, and one that kept it too long would start a third. A reset in mid-frame, with a request pending, must leave the outputs silent.

// File: rtl/fft_seq_pkg.sv
// Package: shared state encoding for the FFT stage sequencer.
// Assumes nothing beyond IEEE 1800-2017 packages.
package fft_seq_pkg;

    // Phases of the issue machine; the retire machine uses IDLE and RUN only.
    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_RUN   = 2'd1,
        SQ_DRAIN = 2'd2
    } sq_state_t;

endpackage

// File: rtl/fft_seq_issue.sv
// Module: issue machine and butterfly counter.
// Latches the upstream frame pulse as a pending request, clears it on
// leaving IDLE, issues NB butterflies one per cycle, then waits in DRAIN
// until the retire side reports completion.
// Assumes: frame_ready is a single-cycle pulse; LOG2 >= 2.
module fft_seq_issue
    import fft_seq_pkg::*;
#(
    parameter int KW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_ready,
    input  logic          retire_done,
    output logic          issue_en,
    output logic          start,
    output logic [KW-1:0] bfly_k
);
    localparam logic [KW-1:0] LAST_K = {KW{1'b1}};

    sq_state_t state;
    logic      pending;

    // Frame starts when idle and a request is waiting.
    always_comb begin
        start    = (state == SQ_IDLE) && pending;
        issue_en = (state == SQ_RUN);
    end

    // Pending request: set by a pulse, cleared only when a frame starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else begin
            pending <= (pending && !start) || frame_ready;
        end
    end

    // Phase sequencing and butterfly counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SQ_IDLE;
            bfly_k <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    bfly_k <= '0;
                    if (start) state <= SQ_RUN;
                end
                SQ_RUN: begin
                    bfly_k <= bfly_k + 1'b1;
                    if (bfly_k == LAST_K) begin
                        state  <= SQ_DRAIN;
                        bfly_k <= '0;
                    end
                end
                SQ_DRAIN: begin
                    if (retire_done) state <= SQ_IDLE;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/fft_seq_addr.sv
// Module: butterfly address and twiddle index generator (combinational).
// Inserts a zero at bit STAGE of the butterfly index to form the upper
// operand address; the lower operand sets that bit. Twiddle index is the
// low STAGE bits of the index (constant 0 at stage 0).
// Assumes: 0 <= STAGE <= KW.
module fft_seq_addr #(
    parameter int KW    = 9,
    parameter int STAGE = 0,
    parameter int TWW   = 1
) (
    input  logic [KW-1:0]  bfly_k,
    output logic [KW:0]    addr_a,
    output logic [KW:0]    addr_b,
    output logic [TWW-1:0] tw
);
    localparam int AW = KW + 1;

    generate
        if (STAGE == 0) begin : g_first
            // Pairs are adjacent: the new zero bit is the LSB.
            assign addr_a = {bfly_k, 1'b0};
            assign tw     = '0;
        end else if (STAGE == KW) begin : g_last
            // Pairs are half a frame apart: the new zero bit is the MSB.
            assign addr_a = {1'b0, bfly_k};
            assign tw     = bfly_k[STAGE-1:0];
        end else begin : g_mid
            // Split the index around bit STAGE.
            assign addr_a = {bfly_k[KW-1:STAGE], 1'b0, bfly_k[STAGE-1:0]};
            assign tw     = bfly_k[STAGE-1:0];
        end
    endgenerate

    // Partner address sets the pairing bit.
    assign addr_b = addr_a | (AW'(1) << STAGE);

endmodule

// File: rtl/fft_seq_delay.sv
// Module: fixed-latency shift line that matches the butterfly datapath.
// Carries a strobe and a payload through LAT registers; reset clears all.
// Assumes: LAT >= 1.
module fft_seq_delay #(
    parameter int W   = 8,
    parameter int LAT = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_vld,
    input  logic [W-1:0] in_data,
    output logic         out_vld,
    output logic [W-1:0] out_data
);
    logic         vld_q  [LAT];
    logic [W-1:0] data_q [LAT];

    generate
        for (genvar i = 0; i < LAT; i++) begin : g_tap
            // One register tap of the latency line.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld_q[i]  <= 1'b0;
                    data_q[i] <= '0;
                end else if (i == 0) begin
                    vld_q[i]  <= in_vld;
                    data_q[i] <= in_data;
                end else begin
                    vld_q[i]  <= vld_q[(i == 0) ? 0 : i-1];
                    data_q[i] <= data_q[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate

    assign out_vld  = vld_q[LAT-1];
    assign out_data = data_q[LAT-1];

endmodule

// File: rtl/fft_seq_retire.sv
// Module: retire machine. Armed when a frame starts, counts delayed
// write strobes and emits a one-cycle done pulse after the last one.
// Assumes: exactly NB strobes arrive per started frame.
module fft_seq_retire
    import fft_seq_pkg::*;
#(
    parameter int KW = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic wr_vld,
    output logic done
);
    localparam logic [KW-1:0] LAST_K = {KW{1'b1}};

    sq_state_t     state;
    logic [KW-1:0] wcnt;

    // Write-back counting and completion pulse generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SQ_IDLE;
            wcnt  <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    wcnt <= '0;
                    if (start) state <= SQ_RUN;
                end
                SQ_RUN: begin
                    if (wr_vld) begin
                        wcnt <= wcnt + 1'b1;
                        if (wcnt == LAST_K) begin
                            done  <= 1'b1;
                            state <= SQ_IDLE;
                            wcnt  <= '0;
                        end
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/fft_stage_seq.sv
// Module: top of the per-stage FFT sequencer. Ties the issue machine,
// address generator, latency line and retire machine together. The
// stage's completion pulse also releases the issue machine from DRAIN.
// Assumes: buffer, twiddle table and butterfly live outside this block.
module fft_stage_seq
    import fft_seq_pkg::*;
#(
    parameter int LOG2  = 10,
    parameter int STAGE = 0,
    parameter int LAT   = 3,
    localparam int KW   = LOG2 - 1,
    localparam int TWW  = (STAGE == 0) ? 1 : STAGE
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_ready,
    output logic            rd_en,
    output logic [LOG2-1:0] rd_addr_a,
    output logic [LOG2-1:0] rd_addr_b,
    output logic [TWW-1:0]  tw_idx,
    output logic            wr_en,
    output logic [LOG2-1:0] wr_addr_a,
    output logic [LOG2-1:0] wr_addr_b,
    output logic            stage_done
);
    logic          start;
    logic [KW-1:0] bfly_k;
    logic [2*LOG2-1:0] wr_pair;

    fft_seq_issue #(.KW(KW)) u_issue (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_ready (frame_ready),
        .retire_done (stage_done),
        .issue_en    (rd_en),
        .start       (start),
        .bfly_k      (bfly_k)
    );

    fft_seq_addr #(.KW(KW), .STAGE(STAGE), .TWW(TWW)) u_addr (
        .bfly_k (bfly_k),
        .addr_a (rd_addr_a),
        .addr_b (rd_addr_b),
        .tw     (tw_idx)
    );

    fft_seq_delay #(.W(2*LOG2), .LAT(LAT)) u_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (rd_en),
        .in_data  ({rd_addr_a, rd_addr_b}),
        .out_vld  (wr_en),
        .out_data (wr_pair)
    );

    assign wr_addr_a = wr_pair[2*LOG2-1:LOG2];
    assign wr_addr_b = wr_pair[LOG2-1:0];

    fft_seq_retire #(.KW(KW)) u_retire (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .wr_vld (wr_en),
        .done   (stage_done)
    );

endmodule

// File: rtl/fft_stage_seq_chk.sv
// Module: property checker for fft_stage_seq, attached by bind.
// Keeps its own LAT-deep copy of the read side to judge the write side.
module fft_stage_seq_chk #(
    parameter int LOG2  = 10,
    parameter int STAGE = 0,
    parameter int LAT   = 3,
    parameter int TWW   = 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            rd_en,
    input logic [LOG2-1:0] rd_addr_a,
    input logic [LOG2-1:0] rd_addr_b,
    input logic [TWW-1:0]  tw_idx,
    input logic            wr_en,
    input logic [LOG2-1:0] wr_addr_a,
    input logic [LOG2-1:0] wr_addr_b,
    input logic            stage_done
);
    localparam int NB = 2 ** (LOG2 - 1);

    logic            m_en [LAT];
    logic [LOG2-1:0] m_a  [LAT];
    logic [LOG2-1:0] m_b  [LAT];
    int unsigned     run_len;

    // Reference latency line for the write side.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LAT; i++) begin
                m_en[i] <= 1'b0;
                m_a[i]  <= '0;
                m_b[i]  <= '0;
            end
        end else begin
            m_en[0] <= rd_en;
            m_a[0]  <= rd_addr_a;
            m_b[0]  <= rd_addr_b;
            for (int i = 1; i < LAT; i++) begin
                m_en[i] <= m_en[i-1];
                m_a[i]  <= m_a[i-1];
                m_b[i]  <= m_b[i-1];
            end
        end
    end

    // Length of the current unbroken run of read strobes.
    always_ff @(posedge clk) begin
        if (!rst_n)     run_len <= 0;
        else if (rd_en) run_len <= run_len + 1;
        else            run_len <= 0;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!rd_en && !wr_en && !stage_done));

    // R2
    run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (run_len < NB));

    // R3
    pair_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (!rd_addr_a[STAGE] && (rd_addr_b == (rd_addr_a | LOG2'(2 ** STAGE)))));

    // R4
    twiddle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> ((STAGE == 0) ? (tw_idx == '0) : (TWW'(rd_addr_a) == tw_idx)));

    // R5
    wr_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en == m_en[LAT-1]);

    // R5
    wr_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr_a == m_a[LAT-1] && wr_addr_b == m_b[LAT-1]));

    // R6
    done_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stage_done |=> !stage_done);

    // R6
    done_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stage_done) |-> ($past(wr_en) && !wr_en));

endmodule

bind fft_stage_seq fft_stage_seq_chk #(
    .LOG2(LOG2), .STAGE(STAGE), .LAT(LAT), .TWW(TWW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .rd_addr_a  (rd_addr_a),
    .rd_addr_b  (rd_addr_b),
    .tw_idx     (tw_idx),
    .wr_en      (wr_en),
    .wr_addr_a  (wr_addr_a),
    .wr_addr_b  (wr_addr_b),
    .stage_done (stage_done)
);

// File: tb/fft_stage_seq_tb.sv
// Bench: three sequencer instances (first, middle, last stage) of a
// 32-point configuration, checked on every cycle against arithmetic
// expectations derived from the frame start cycle.
module fft_stage_seq_tb;
    localparam int TCLK = 10;
    localparam int LOG2 = 5;
    localparam int NB   = 2 ** (LOG2 - 1);
    localparam int LAT  = 3;
    localparam int SMID = 2;
    localparam int STOP = LOG2 - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_ready = 1'b0;

    logic            rd_en   [3];
    logic [LOG2-1:0] rd_a    [3];
    logic [LOG2-1:0] rd_b    [3];
    logic [LOG2-1:0] tw      [3];
    logic            wr_en   [3];
    logic [LOG2-1:0] wr_a    [3];
    logic [LOG2-1:0] wr_b    [3];
    logic            done    [3];
    logic [0:0]      tw0;
    logic [SMID-1:0] tw1;
    logic [STOP-1:0] tw2;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #(TCLK/2) clk = ~clk;

    fft_stage_seq #(.LOG2(LOG2), .STAGE(0), .LAT(LAT)) u_dut_s0 (
        .clk(clk), .rst_n(rst_n), .frame_ready(frame_ready),
        .rd_en(rd_en[0]), .rd_addr_a(rd_a[0]), .rd_addr_b(rd_b[0]), .tw_idx(tw0),
        .wr_en(wr_en[0]), .wr_addr_a(wr_a[0]), .wr_addr_b(wr_b[0]), .stage_done(done[0]));

    fft_stage_seq #(.LOG2(LOG2), .STAGE(SMID), .LAT(LAT)) u_dut (
        .clk(clk), .rst_n(rst_n), .frame_ready(frame_ready),
        .rd_en(rd_en[1]), .rd_addr_a(rd_a[1]), .rd_addr_b(rd_b[1]), .tw_idx(tw1),
        .wr_en(wr_en[1]), .wr_addr_a(wr_a[1]), .wr_addr_b(wr_b[1]), .stage_done(done[1]));

    fft_stage_seq #(.LOG2(LOG2), .STAGE(STOP), .LAT(LAT)) u_dut_top (
        .clk(clk), .rst_n(rst_n), .frame_ready(frame_ready),
        .rd_en(rd_en[2]), .rd_addr_a(rd_a[2]), .rd_addr_b(rd_b[2]), .tw_idx(tw2),
        .wr_en(wr_en[2]), .wr_addr_a(wr_a[2]), .wr_addr_b(wr_b[2]), .stage_done(done[2]));

    assign tw[0] = LOG2'(tw0);
    assign tw[1] = LOG2'(tw1);
    assign tw[2] = LOG2'(tw2);

    function automatic int stage_of(input int i);
        return (i == 0) ? 0 : ((i == 1) ? SMID : STOP);
    endfunction

    function automatic int upper(input int k, input int s);
        return ((k >> s) << (s + 1)) | (k & ((1 << s) - 1));
    endfunction

    task automatic report(input string req, input int idx, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s inst%0d t=%0t actual=%0h expected=%0h", req, idx, $time, act, exp);
        end
    endtask

    // Check all instances at one cycle; m = cycles since the first read of the
    // active frame (negative: no frame active).
    task automatic check_cycle(input int m);
        for (int i = 0; i < 3; i++) begin
            int s = stage_of(i);
            bit e_rd = (m >= 0) && (m < NB);
            bit e_wr = (m >= LAT) && (m < NB + LAT);
            bit e_dn = (m == NB + LAT);
            // R2 read strobe timing
            report("R2", i, int'(rd_en[i]), int'(e_rd));
            if (e_rd) begin
                // R3 operand addresses
                report("R3", i, int'({rd_a[i], rd_b[i]}),
                       (upper(m, s) << LOG2) | (upper(m, s) + (1 << s)));
                // R4 twiddle index
                report("R4", i, int'(tw[i]), m & ((1 << s) - 1));
            end
            // R5 delayed write strobe and addresses
            report("R5", i, int'(wr_en[i]), int'(e_wr));
            if (e_wr) begin
                report("R5", i, int'({wr_a[i], wr_b[i]}),
                       (upper(m - LAT, s) << LOG2) | (upper(m - LAT, s) + (1 << s)));
            end
            // R6 completion pulse
            report("R6", i, int'(done[i]), int'(e_dn));
        end
    endtask

    task automatic pulse_request();
        frame_ready = 1'b1;
        @(negedge clk);
        frame_ready = 1'b0;
    endtask

    // Watchdog: an expired run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            report("R1", i, int'({rd_en[i], wr_en[i], done[i]}), 0);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // Single frame: pulse sampled at P0, first read after P1.
        pulse_request();
        for (int n = 1; n <= NB + 10; n++) begin
            @(negedge clk);
            check_cycle(n - 1);
        end

        // R7: second request mid-frame gives exactly one follow-on frame.
        pulse_request();
        for (int n = 1; n <= 2 * NB + 20; n++) begin
            @(negedge clk);
            if (n >= NB + 6) check_cycle(n - (NB + 6));
            else             check_cycle(n - 1);
            if (n == 5) frame_ready = 1'b1;
            if (n == 6) frame_ready = 1'b0;
        end
        // R7: no third frame
        for (int n = 0; n < 10; n++) begin
            @(negedge clk);
            report("R7", 1, int'(rd_en[1] | wr_en[1] | done[1]), 0);
        end

        // R8: reset mid-frame with a request pending.
        pulse_request();
        for (int n = 1; n <= 8; n++) begin
            @(negedge clk);
            if (n == 3) frame_ready = 1'b1;
            if (n == 4) frame_ready = 1'b0;
            if (n == 6) rst_n = 1'b0;
            if (n == 8) rst_n = 1'b1;
        end
        for (int n = 0; n < NB + 10; n++) begin
            @(negedge clk);
            for (int i = 0; i < 3; i++) begin
                report("R8", i, int'({rd_en[i], wr_en[i], done[i]}), 0);
            end
        end

        // Recovery frame after the abandoned one.
        pulse_request();
        for (int n = 1; n <= NB + 6; n++) begin
            @(negedge clk);
            check_cycle(n - 1);
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule